// File: doc/BRIEF.md
# Brick-Pattern XOR Network PUF Array

This block is a synthesizable behavioural model of a digital physically unclonable function. It is a grid of `N` rows by `M` columns of XOR cells. Each row carries one challenge bit from the left edge to the right edge. At every column the bit is XORed with an operand. When the cell's connection bit is set, that operand is a neighbouring row's value. When the connection bit is clear, the operand is a fixed idle level. The neighbour a cell reads depends on the parity of its row and of its column. Even rows look back one column. Odd rows read an even row's result from the same column. The rows therefore interlock like courses of brickwork rather than forming separate chains.

The per-chip randomness is modelled by a configuration vector of `N*M` connection bits, loaded serially. Challenges enter on a valid/ready stream. A challenge is accepted when `chal_valid` and `chal_ready` are both high. The response is registered and presented on a valid/ready stream one clock later. Back-pressure works as follows. While a response is held un-taken (`rsp_valid` high, `rsp_ready` low), no new challenge is accepted. No challenge is accepted during configuration loading either.

Top module: `puf_xor_brick`

## Requirements
- R1: After reset `rsp_valid` is 0, `rsp_data` is 0, and every connection bit is 0.
- R2: In each cycle with `cfg_shift` high, the configuration shifts left by one place and `cfg_sin` enters at bit 0. Cell (row i, column j) uses configuration bit `i*M+j`, so the first of `N*M` shifted bits lands on cell (N-1, M-1).
- R3: Row i at column j produces `x(i,j) = x(i,j-1) XOR op`, where `x(i,-1)` is challenge bit i. Response bit i is `x(i,M-1)`.
- R4: For an even row with its connection bit set, `op` is `x(i+1,j-1)` at even columns and `x(i-1,j-1)` at odd columns.
- R5: For an odd row with its connection bit set, `op` is `x(i-1,j)` at even columns and `x(i+1,j)` at odd columns.
- R6: With the connection bit clear, `op` is the idle level `IDLE_LVL` (default 1). With all bits clear and M even, the response therefore equals the challenge.
- R7: A neighbour row outside 0..N-1 is dangling and gives `op = IDLE_LVL` whatever the connection bit is.
- R8: A challenge accepted at a clock edge appears on `rsp_data` with `rsp_valid` high right after that edge.
- R9: `chal_ready = !cfg_shift && (!rsp_valid || rsp_ready)`. While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` and `rsp_valid` stay unchanged.
- R10: During loading (`cfg_shift` high) `chal_ready` is low and `rsp_data` is unchanged.
- R11: The same challenge under the same configuration always gives the same response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_shift | input | 1 | Shift enable for the connection vector |
| cfg_sin | input | 1 | Serial connection bit, first bit ends at the top index |
| chal_valid | input | 1 | Challenge offered |
| chal_ready | output | 1 | Challenge can be accepted |
| chal_data | input | N | Challenge, bit i enters row i |
| rsp_valid | output | 1 | Response held |
| rsp_ready | input | 1 | Response taken |
| rsp_data | output | N | Response, bit i leaves row i |

## Verification
Dangling neighbours at the top and bottom rows only matter when the connection bits of those edge cells are set. Odd-row operands come from same-column results, so they only show up when the even rows have already been disturbed. Both effects are reached by loading all-ones and several random connection vectors and sweeping all 256 challenges of the 8x8 default under each. A bench recurrence model predicts every response. Back-pressure and the load freeze are hardest to hit together. The bench parks a response with `rsp_ready` low, offers a new challenge, and reloads the configuration under it. It then checks that nothing moves until the response is taken.

// File: rtl/puf_brick_pkg.sv
package puf_brick_pkg;
  // Kind of neighbour an array cell uses.
  typedef enum logic [1:0] {
    NB_PREV_BELOW = 2'd0, // row i+1, previous column
    NB_PREV_ABOVE = 2'd1, // row i-1, previous column
    NB_SAME_ABOVE = 2'd2, // row i-1, same column
    NB_SAME_BELOW = 2'd3  // row i+1, same column
  } nb_kind_e;

  function automatic nb_kind_e nb_kind(input int row, input int col);
    if (row % 2 == 0) return (col % 2 == 0) ? NB_PREV_BELOW : NB_PREV_ABOVE;
    else              return (col % 2 == 0) ? NB_SAME_ABOVE : NB_SAME_BELOW;
  endfunction

  function automatic int nb_row(input int row, input int col);
    nb_kind_e k;
    k = nb_kind(row, col);
    if (k == NB_PREV_BELOW || k == NB_SAME_BELOW) return row + 1;
    return row - 1;
  endfunction

  function automatic int cell_index(input int row, input int col, input int cols);
    return row * cols + col;
  endfunction
endpackage

// File: rtl/puf_cfg_shreg.sv
module puf_cfg_shreg #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         sin,
  output logic [W-1:0] cfg
);
  generate
    if (W == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst)           cfg <= '0;
        else if (shift_en) cfg <= sin;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst)           cfg <= '0;
        else if (shift_en) cfg <= {cfg[W-2:0], sin};
      end
    end
  endgenerate
endmodule

// File: rtl/puf_xor_cell.sv
module puf_xor_cell #(
  parameter bit IDLE_LVL = 1'b1
) (
  input  logic prev,
  input  logic nb,
  input  logic conn,
  output logic q
);
  logic op;
  always_comb begin
    op = conn ? nb : IDLE_LVL;
    q  = prev ^ op;
  end
endmodule

// File: rtl/puf_brick_column.sv
module puf_brick_column
  import puf_brick_pkg::*;
#(
  parameter int N        = 8,
  parameter int COL      = 0,
  parameter bit IDLE_LVL = 1'b1
) (
  input  logic [N-1:0] prev,
  input  logic [N-1:0] conn,
  output logic [N-1:0] q
);
  // Even rows first (depend on previous column), then odd rows read even rows.
  for (genvar r = 0; r < N; r++) begin : g_row
    localparam int NBR = nb_row(r, COL);
    localparam nb_kind_e KIND = nb_kind(r, COL);
    localparam bit DANGLE = (NBR < 0) || (NBR >= N);
    logic nb_w;
    if (DANGLE) begin : g_dangle
      assign nb_w = IDLE_LVL;
    end else if (KIND == NB_PREV_BELOW || KIND == NB_PREV_ABOVE) begin : g_prev
      assign nb_w = prev[NBR];
    end else begin : g_same
      assign nb_w = q[NBR];
    end
    puf_xor_cell #(.IDLE_LVL(IDLE_LVL)) u_cell (
      .prev (prev[r]),
      .nb   (nb_w),
      .conn (conn[r]),
      .q    (q[r])
    );
  end
endmodule

// File: rtl/puf_xor_brick.sv
module puf_xor_brick
  import puf_brick_pkg::*;
#(
  parameter int N        = 8,
  parameter int M        = 8,
  parameter bit IDLE_LVL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_shift,
  input  logic         cfg_sin,
  input  logic         chal_valid,
  output logic         chal_ready,
  input  logic [N-1:0] chal_data,
  output logic         rsp_valid,
  input  logic         rsp_ready,
  output logic [N-1:0] rsp_data
);
  localparam int CW = N * M;

  logic [CW-1:0]      cfg;
  logic [M:0][N-1:0]  stage;
  logic               accept;

  puf_cfg_shreg #(.W(CW)) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .shift_en (cfg_shift),
    .sin      (cfg_sin),
    .cfg      (cfg)
  );

  assign stage[0] = chal_data;

  for (genvar c = 0; c < M; c++) begin : g_col
    logic [N-1:0] conn_c;
    for (genvar r = 0; r < N; r++) begin : g_tap
      assign conn_c[r] = cfg[cell_index(r, c, M)];
    end
    puf_brick_column #(.N(N), .COL(c), .IDLE_LVL(IDLE_LVL)) u_col (
      .prev (stage[c]),
      .conn (conn_c),
      .q    (stage[c+1])
    );
  end

  assign chal_ready = !cfg_shift && (!rsp_valid || rsp_ready);
  assign accept     = chal_valid && chal_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_data  <= stage[M];
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/puf_xor_brick_chk.sv
module puf_xor_brick_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         cfg_shift,
  input logic         chal_valid,
  input logic         chal_ready,
  input logic         rsp_valid,
  input logic         rsp_ready,
  input logic [N-1:0] rsp_data
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!rsp_valid && rsp_data == '0));

  a_r8_accept_gives_rsp: assert property (@(posedge clk) disable iff (rst)
    (chal_valid && chal_ready) |=> rsp_valid);

  a_r8_rise_needs_accept: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_valid) |-> $past(chal_valid && chal_ready));

  a_r9_hold_under_backpressure: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  a_r9_no_accept_when_full: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |-> !chal_ready);

  a_r10_ready_low_in_load: assert property (@(posedge clk) disable iff (rst)
    cfg_shift |-> !chal_ready);

  a_r10_rsp_frozen_in_load: assert property (@(posedge clk) disable iff (rst)
    cfg_shift |=> $stable(rsp_data));
endmodule

bind puf_xor_brick puf_xor_brick_chk #(.N(N)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_shift  (cfg_shift),
  .chal_valid (chal_valid),
  .chal_ready (chal_ready),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_data   (rsp_data)
);

// File: tb/tb_puf_xor_brick.sv
`timescale 1ns/1ps
module tb_puf_xor_brick;
  localparam int N = 8;
  localparam int M = 8;
  localparam int CW = N * M;
  localparam bit IDLE = 1'b1;

  logic clk = 0, rst = 1;
  logic cfg_shift = 0, cfg_sin = 0;
  logic chal_valid = 0, rsp_ready = 1;
  logic [N-1:0] chal_data = '0;
  logic chal_ready, rsp_valid;
  logic [N-1:0] rsp_data;

  int checks = 0, fails = 0;
  bit finished = 0;
  bit [CW-1:0] cfg_m = '0;

  always #10 clk = ~clk;

  puf_xor_brick #(.N(N), .M(M), .IDLE_LVL(IDLE)) dut (
    .clk(clk), .rst(rst), .cfg_shift(cfg_shift), .cfg_sin(cfg_sin),
    .chal_valid(chal_valid), .chal_ready(chal_ready), .chal_data(chal_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data));

  // Bench model of the recurrence (R3..R7).
  function automatic bit [N-1:0] model(input bit [CW-1:0] v, input bit [N-1:0] ch);
    bit [N-1:0] cur, nxt;
    cur = ch;
    for (int j = 0; j < M; j++) begin
      for (int i = 0; i < N; i += 2) begin
        int nb = (j % 2 == 0) ? i + 1 : i - 1;
        bit op = IDLE;
        if (v[i*M+j] && nb >= 0 && nb < N) op = cur[nb];
        nxt[i] = cur[i] ^ op;
      end
      for (int i = 1; i < N; i += 2) begin
        int nb = (j % 2 == 0) ? i - 1 : i + 1;
        bit op = IDLE;
        if (v[i*M+j] && nb >= 0 && nb < N) op = nxt[nb];
        nxt[i] = cur[i] ^ op;
      end
      cur = nxt;
    end
    return cur;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic load_cfg(input bit [CW-1:0] v);
    for (int b = CW - 1; b >= 0; b--) begin
      @(negedge clk);
      cfg_shift = 1; cfg_sin = v[b];
    end
    @(negedge clk);
    cfg_shift = 0;
    cfg_m = v;
  endtask

  task automatic run_chal(input bit [N-1:0] c, input string req, output logic [N-1:0] got);
    @(negedge clk);
    chal_valid = 1; chal_data = c; rsp_ready = 1;
    @(posedge clk);
    @(negedge clk);
    chal_valid = 0;
    got = rsp_data;
    chk(rsp_valid === 1'b1, {req, " valid"}, {7'b0, rsp_valid}, 8'h01);
    chk(rsp_data === model(cfg_m, c), req, rsp_data, model(cfg_m, c));
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] r1, r2, held;
    void'($urandom(32'hC0FFEE));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk(rsp_valid === 1'b0, "R1 valid", {7'b0, rsp_valid}, 8'h00);
    chk(rsp_data === '0, "R1 data", rsp_data, 8'h00);
    chk(chal_ready === 1'b1, "R9 ready idle", {7'b0, chal_ready}, 8'h01);
    // R1/R6: cleared config, M even -> identity
    run_chal(8'hA5, "R1_R6 cleared cfg identity", r1);
    chk(r1 === 8'hA5, "R6 identity", r1, 8'hA5);

    // R7/R4/R5: all connections set, exhaustive
    load_cfg('1);
    for (int c = 0; c < 256; c++) run_chal(c[N-1:0], "R7 all-ones sweep", r1);

    // R2: single connection bit, first shifted bit maps to cell (N-1,M-1)
    load_cfg({1'b1, {(CW-1){1'b0}}});
    for (int c = 0; c < 256; c++) run_chal(c[N-1:0], "R2 single-bit map", r1);
    load_cfg({{(CW-1){1'b0}}, 1'b1});
    run_chal(8'h02, "R2 cell0 map", r1);

    // R3/R4/R5: random configurations, exhaustive
    for (int k = 0; k < 4; k++) begin
      bit [CW-1:0] v;
      v = {$urandom, $urandom};
      load_cfg(v);
      for (int c = 0; c < 256; c++) run_chal(c[N-1:0], "R3_R4_R5 random sweep", r1);
    end

    // R11: repeatability
    for (int k = 0; k < 16; k++) begin
      bit [N-1:0] c;
      c = $urandom;
      run_chal(c, "R11 first", r1);
      run_chal(c, "R11 repeat", r2);
      chk(r1 === r2, "R11 same response", r2, r1);
    end

    // R9: back-pressure
    @(negedge clk);
    rsp_ready = 0; chal_valid = 1; chal_data = 8'h3C;
    @(posedge clk);
    @(negedge clk);
    held = rsp_data;
    chk(held === model(cfg_m, 8'h3C), "R8 first held", held, model(cfg_m, 8'h3C));
    chal_data = 8'hC3;
    for (int k = 0; k < 3; k++) begin
      chk(chal_ready === 1'b0, "R9 ready low when full", {7'b0, chal_ready}, 8'h00);
      @(negedge clk);
      chk(rsp_valid === 1'b1 && rsp_data === held, "R9 held stable", rsp_data, held);
    end
    chal_valid = 0;

    // R10: reload while response is parked
    for (int b = CW - 1; b >= 0; b--) begin
      @(negedge clk);
      cfg_shift = 1; cfg_sin = b[0];
      rsp_ready = b[1];
      chal_valid = 1; chal_data = 8'h0F;
      if (b % 16 == 0)
        chk(chal_ready === 1'b0, "R10 ready low in load", {7'b0, chal_ready}, 8'h00);
    end
    @(negedge clk);
    chk(rsp_data === held, "R10 rsp frozen in load", rsp_data, held);
    cfg_shift = 0; chal_valid = 0; rsp_ready = 1;
    for (int b = 0; b < CW; b++) cfg_m[b] = b[0];
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R9 drained", {7'b0, rsp_valid}, 8'h00);
    run_chal(8'h0F, "R10 new cfg used", r1);
    run_chal(8'h00, "R3 zero chal", r1);
    run_chal(8'hFF, "R3 ones chal", r1);

    // R1: reset mid-stream clears response and config
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk(rsp_valid === 1'b0 && rsp_data === '0, "R1 re-reset", rsp_data, 8'h00);
    cfg_m = '0;
    run_chal(8'h5A, "R1 cfg cleared", r1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule